// File: doc/BRIEF.md
# Digital Audio Transmitter Status Inserter

This block supplies the per-subframe channel-status (C) and user (U) bits for a biphase-mark audio transmitter, plus a one-hot decode of the transmit source selection. A 40-bit control word provides the first five bytes of channel status. Every later bit in the 192-frame block is sent as zero. In consumer mode (control bit 0 cleared), channel-status bits 20 to 23 carry a per-channel number code instead of register contents. The U bit is either held low or looped back from a receiver, and the loopback only happens while the receiver PLL reports lock.

The transmitter pulses `sub_strobe` once per subframe and marks the subframe as left or right. A frame counter inside the block follows the position in the 192-frame block: it advances after each right subframe and restarts at frame 0 when `block_start` comes with the strobe. The C bit, U bit and frame index for a strobed subframe are registered and appear one cycle after the strobe, marked by `out_valid`. Line coding, preambles, parity and audio data are handled by other blocks.

Top module: `tx_status_inserter`

## Requirements
- R1: For frames 0 to 39, the C bit equals `cs_ctrl[frame]`, except for frames 20 to 23 in consumer mode.
- R2: For frames 40 to 191, the C bit is 0 whatever the control word holds.
- R3: In consumer mode (`cs_ctrl[0]`=0) with `chan_num_en`=1, a left subframe (`sub_is_right`=0) emits 1,0,0,0 on frames 20,21,22,23.
- R4: In consumer mode with `chan_num_en`=1, a right subframe (`sub_is_right`=1) emits 0,1,0,0 on frames 20,21,22,23.
- R5: In consumer mode with `chan_num_en`=0, frames 20 to 23 emit 0 on both subframes.
- R6: In professional mode (`cs_ctrl[0]`=1), frames 20 to 23 emit `cs_ctrl[20]` to `cs_ctrl[23]` and `chan_num_en` has no effect.
- R7: With `user_loop_en`=0, the U bit is 0.
- R8: With `user_loop_en`=1 and `pll_locked`=1, the U bit equals `rx_user_bit`.
- R9: With `user_loop_en`=1 and `pll_locked`=0, the U bit is 0.
- R10: `src_onehot` decodes `src_sel` combinationally as follows: 00 gives 3'b001 (ADC data), 01 gives 3'b010 (serial input data), 10 gives 3'b100 (receiver through-data), and 11 gives 3'b000 (no source).
- R11: The frame index of a strobed subframe is 0 when `block_start` is high. Otherwise it is the count kept by the block, which advances by one after each right subframe and wraps from 191 to 0.
- R12: `c_bit`, `u_bit` and `frame_idx` are updated one cycle after a strobe, and `out_valid` is high in that cycle only. Without a strobe the three values hold. After reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_ctrl | input | 40 | Channel-status control word; bit k drives status bit k; bit 0 is 1 for professional mode |
| chan_num_en | input | 1 | Enables the channel-number code in consumer mode |
| user_loop_en | input | 1 | Enables user-bit loopback from the receiver |
| pll_locked | input | 1 | Receiver PLL lock flag |
| rx_user_bit | input | 1 | Recovered user bit |
| block_start | input | 1 | With the strobe, forces this subframe to frame 0 |
| sub_strobe | input | 1 | One pulse per subframe |
| sub_is_right | input | 1 | 1 for a right subframe, 0 for a left subframe |
| src_sel | input | 2 | Transmit source select |
| c_bit | output | 1 | Channel-status bit of the last strobed subframe |
| u_bit | output | 1 | User bit of the last strobed subframe |
| frame_idx | output | 8 | Frame index of the last strobed subframe |
| out_valid | output | 1 | High for one cycle after a strobe |
| src_onehot | output | 3 | One-hot decoded source; all zeros for the unused code |

## Verification
The bench runs full 192-frame blocks under all four combinations of consumer/professional mode and channel-number enable. Each combination is run with two control words that are bitwise complements of each other. This shows whether a bit comes from the register, from the channel code or from the forced-zero tail, and whether left and right codes are swapped. The user-bit inputs follow counter-derived patterns, so every loopback, lock and receiver-bit combination occurs on left and right subframes. A mid-block restart and idle cycles without a strobe check the restart, the wrap and the hold behaviour. All four source codes are swept.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [1:0] {
    SRC_ADC    = 2'b00,
    SRC_SERIAL = 2'b01,
    SRC_RXTHRU = 2'b10,
    SRC_NONE   = 2'b11
  } tx_src_e;

  // one-hot source decode; the unused code yields no source
  function automatic logic [2:0] src_decode(input logic [1:0] sel);
    logic [2:0] oh;
    case (tx_src_e'(sel))
      SRC_ADC:    oh = 3'b001;
      SRC_SERIAL: oh = 3'b010;
      SRC_RXTHRU: oh = 3'b100;
      default:    oh = 3'b000;
    endcase
    return oh;
  endfunction

  // user bit: loopback only while enabled and locked
  function automatic logic user_gate(input logic loop_en, input logic locked,
                                     input logic rx_bit);
    return loop_en & locked & rx_bit;
  endfunction

endpackage

// File: rtl/txs_frame_ctr.sv
module txs_frame_ctr #(
  parameter int BLOCK_LEN = 192,
  parameter int FW        = $clog2(BLOCK_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          block_start,
  input  logic          is_right,
  output logic [FW-1:0] cur_frame
);
  localparam logic [FW-1:0] LAST = FW'(BLOCK_LEN - 1);

  logic [FW-1:0] cnt_q;
  logic          wrap_evt;     // right subframe of the last frame
  logic          restart_evt;  // block start qualified by strobe

  assign restart_evt = strobe & block_start;
  assign cur_frame   = restart_evt ? '0 : cnt_q;
  assign wrap_evt    = strobe & is_right & (cur_frame == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (strobe && is_right)
      cnt_q <= wrap_evt ? '0 : cur_frame + 1'b1;
    else if (restart_evt)
      cnt_q <= '0;
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt_q == '0); // R11
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R11
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_evt && !is_right) |=> cnt_q == '0); // R11
  AST_FRAME_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !is_right && !block_start) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/txs_cs_select.sv
module txs_cs_select #(
  parameter int CS_W = 40,
  parameter int FW   = 8
) (
  input  logic [CS_W-1:0] ctrl,
  input  logic [FW-1:0]   frame,
  input  logic            is_right,
  input  logic            chan_en,
  output logic            cs_bit,
  output logic            in_chan_field,
  output logic            consumer
);
  localparam int CH_LO = 20;
  localparam int CH_HI = 23;

  // channel-number code bit for position frame (20..23)
  function automatic logic chan_code(input logic [FW-1:0] f, input logic right,
                                     input logic en);
    logic [FW-1:0] pos;
    pos = f - FW'(CH_LO);
    return en & (pos == (right ? FW'(1) : FW'(0)));
  endfunction

  function automatic logic reg_bit(input logic [CS_W-1:0] c, input logic [FW-1:0] f);
    logic [CS_W-1:0] sh;
    sh = c >> f;
    return sh[0];
  endfunction

  logic in_reg_range;

  assign consumer      = ~ctrl[0];
  assign in_reg_range  = (int'(frame) < CS_W);
  assign in_chan_field = (int'(frame) >= CH_LO) && (int'(frame) <= CH_HI);

  always_comb begin
    if (!in_reg_range)
      cs_bit = 1'b0;
    else if (consumer && in_chan_field)
      cs_bit = chan_code(frame, is_right, chan_en);
    else
      cs_bit = reg_bit(ctrl, frame);
  end

endmodule

// File: rtl/tx_status_inserter.sv
module tx_status_inserter #(
  parameter int CS_W      = 40,
  parameter int BLOCK_LEN = 192,
  parameter int FW        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CS_W-1:0] cs_ctrl,
  input  logic            chan_num_en,
  input  logic            user_loop_en,
  input  logic            pll_locked,
  input  logic            rx_user_bit,
  input  logic            block_start,
  input  logic            sub_strobe,
  input  logic            sub_is_right,
  input  logic [1:0]      src_sel,
  output logic            c_bit,
  output logic            u_bit,
  output logic [FW-1:0]   frame_idx,
  output logic            out_valid,
  output logic [2:0]      src_onehot
);
  import txs_pkg::*;

  logic [FW-1:0] cur_frame;
  logic          cs_next;
  logic          u_next;
  logic          in_chan_field;
  logic          consumer;

  txs_frame_ctr #(.BLOCK_LEN(BLOCK_LEN), .FW(FW)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (sub_strobe),
    .block_start(block_start),
    .is_right   (sub_is_right),
    .cur_frame  (cur_frame)
  );

  txs_cs_select #(.CS_W(CS_W), .FW(FW)) u_cs (
    .ctrl         (cs_ctrl),
    .frame        (cur_frame),
    .is_right     (sub_is_right),
    .chan_en      (chan_num_en),
    .cs_bit       (cs_next),
    .in_chan_field(in_chan_field),
    .consumer     (consumer)
  );

  assign u_next     = user_gate(user_loop_en, pll_locked, rx_user_bit);
  assign src_onehot = src_decode(src_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_bit     <= 1'b0;
      u_bit     <= 1'b0;
      frame_idx <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= sub_strobe;
      if (sub_strobe) begin
        c_bit     <= cs_next;
        u_bit     <= u_next;
        frame_idx <= cur_frame;
      end
    end
  end

  AST_CS_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && int'(frame_idx) >= CS_W) |-> !c_bit); // R2
  AST_CHAN_NOEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_strobe && consumer && in_chan_field && !chan_num_en) |=> !c_bit); // R5
  AST_U_NO_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_strobe && !user_loop_en) |=> !u_bit); // R7
  AST_U_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_strobe && user_loop_en && pll_locked) |=> u_bit == $past(rx_user_bit)); // R8
  AST_U_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_strobe && !pll_locked) |=> !u_bit); // R9
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_onehot) && ((src_sel == 2'b11) == (src_onehot == 3'b000))); // R10
  AST_START_FRAME0: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_strobe && block_start) |=> frame_idx == '0); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_strobe |=> (!out_valid && $stable(c_bit) && $stable(u_bit) && $stable(frame_idx))); // R12

endmodule

// File: tb/test_tx_status_inserter.sv
module test_tx_status_inserter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] cs_ctrl = '0;
  logic        chan_num_en = 1'b0, user_loop_en = 1'b0, pll_locked = 1'b0;
  logic        rx_user_bit = 1'b0, block_start = 1'b0, sub_strobe = 1'b0;
  logic        sub_is_right = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic        c_bit, u_bit, out_valid;
  logic [7:0]  frame_idx;
  logic [2:0]  src_onehot;

  int total = 0;
  int bad   = 0;
  int exp_f = 0;

  always #5 clk = ~clk;

  tx_status_inserter i_tx_status_inserter (
    .clk(clk), .rst_n(rst_n), .cs_ctrl(cs_ctrl), .chan_num_en(chan_num_en),
    .user_loop_en(user_loop_en), .pll_locked(pll_locked), .rx_user_bit(rx_user_bit),
    .block_start(block_start), .sub_strobe(sub_strobe), .sub_is_right(sub_is_right),
    .src_sel(src_sel), .c_bit(c_bit), .u_bit(u_bit), .frame_idx(frame_idx),
    .out_valid(out_valid), .src_onehot(src_onehot)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected C bit, restated as field lookup
  function automatic int exp_c(input int f, input logic [39:0] ctl, input bit right,
                               input bit en);
    int code;
    if (f >= 40) return 0;
    if (ctl[0] == 1'b0 && f >= 20 && f <= 23) begin
      code = right ? 2 : 1;           // bit (f-20) of the 4-bit code
      return en ? ((code >> (f - 20)) & 1) : 0;
    end
    return int'(ctl[f]);
  endfunction

  function automatic string c_req(input int f, input logic [39:0] ctl, input bit right,
                                  input bit en);
    if (f >= 40) return "R2";
    if (f >= 20 && f <= 23) begin
      if (ctl[0]) return "R6";
      if (!en) return "R5";
      return right ? "R4" : "R3";
    end
    return "R1";
  endfunction

  // one strobed subframe: drive at negedge, check at following negedge
  task automatic subframe(input bit right, input bit bs, input int seq);
    int f;
    int eu;
    sub_strobe   = 1'b1;
    sub_is_right = right;
    block_start  = bs;
    user_loop_en = seq[3];
    pll_locked   = seq[4];
    rx_user_bit  = seq[0] ^ seq[2];
    f  = bs ? 0 : exp_f;
    eu = (seq[3] && seq[4]) ? int'(seq[0] ^ seq[2]) : 0;
    @(negedge clk);
    check(int'(c_bit) == exp_c(f, cs_ctrl, right, chan_num_en),
          c_req(f, cs_ctrl, right, chan_num_en), int'(c_bit),
          exp_c(f, cs_ctrl, right, chan_num_en));
    if (!seq[3])      check(int'(u_bit) == eu, "R7", int'(u_bit), eu);
    else if (seq[4])  check(int'(u_bit) == eu, "R8", int'(u_bit), eu);
    else              check(int'(u_bit) == eu, "R9", int'(u_bit), eu);
    check(int'(frame_idx) == f, "R11", int'(frame_idx), f);
    check(out_valid == 1'b1, "R12", int'(out_valid), 1);
    exp_f = right ? ((f + 1) % 192) : f;
  endtask

  task automatic idle_check();
    logic c0, u0;
    logic [7:0] f0;
    c0 = c_bit; u0 = u_bit; f0 = frame_idx;
    sub_strobe = 1'b0;
    cs_ctrl = ~cs_ctrl;
    rx_user_bit = ~rx_user_bit;
    block_start = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R12", int'(out_valid), 0);
    check(c_bit == c0 && u_bit == u0 && frame_idx == f0, "R12",
          int'({c_bit, u_bit, frame_idx}), int'({c0, u0, f0}));
    cs_ctrl = ~cs_ctrl;
    block_start = 1'b0;
  endtask

  initial begin
    int seq = 0;
    repeat (3) @(negedge clk);
    check(c_bit == 0 && u_bit == 0 && frame_idx == 0 && out_valid == 0, "R12",
          int'({c_bit, u_bit, frame_idx, out_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: source decode sweep
    for (int s = 0; s < 4; s++) begin
      int e;
      src_sel = 2'(s);
      #1;
      e = (s < 3) ? (1 << s) : 0;
      check(int'(src_onehot) == e, "R10", int'(src_onehot), e);
    end

    // full blocks over mode x enable x two complementary control words
    for (int m = 0; m < 8; m++) begin
      logic [39:0] base;
      base = (m[2]) ? 40'h5A_C3_96_3C_A5 : ~40'h5A_C3_96_3C_A5;
      base[0] = m[0];                 // 0 consumer, 1 professional
      cs_ctrl = base;
      chan_num_en = m[1];
      for (int fr = 0; fr < 192; fr++) begin
        subframe(1'b0, fr == 0, seq); seq++;
        subframe(1'b1, 1'b0, seq);    seq++;
        if (fr == 21 || fr == 100) idle_check();
      end
      // counter wrapped: next frame without block start is 0 (R11)
      subframe(1'b0, 1'b0, seq); seq++;
      subframe(1'b1, 1'b0, seq); seq++;
    end

    // mid-block restart (R11)
    cs_ctrl = 40'h00_00_F0_00_00;
    chan_num_en = 1'b1;
    for (int fr = 0; fr < 30; fr++) begin
      subframe(1'b0, 1'b0, seq); seq++;
      subframe(1'b1, 1'b0, seq); seq++;
    end
    for (int fr = 0; fr < 25; fr++) begin
      subframe(1'b0, fr == 0, seq); seq++;
      subframe(1'b1, 1'b0, seq); seq++;
    end

    sub_strobe = 1'b0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule